// File: doc/BRIEF.md
# I2C Peripheral Power-Up Init Sequencer

This block runs a fixed configuration script once after reset. It drives a byte-level I2C master engine through a small command port: start condition, stop condition, byte write with acknowledge status, and a bus reset command for the DACs. The engine does the bit-level SCL/SDA timing and is not part of this block. There are three targets. The first is a two-channel PWM relay/LED driver, which receives a control byte and four data bytes. The second and third are two DACs, each of which receives one configuration byte.

The script is built from three inputs: the hold duty, the close duty and the DAC configuration byte. The three targets handle errors differently. The driver transfer stops at the first NACK on a written byte, closes the bus with a stop condition and records an error. The DAC transfers read the acknowledge result but never act on it, and each one begins with a bus reset command. `init_done` rises after the stop condition of the last DAC has completed. It rises whether or not the driver reported an error.

Top module: `i2c_init_seq`

## Requirements
- R1: While reset is held, and after it until the engine has once reported `eng_idle`=1 at a clock edge, `cmd_valid`, `init_done` and `drv_err` are 0.
- R2: Every command is a `cmd_valid` pulse lasting one cycle. After a pulse, no further command is issued until the engine pulses `eng_done`.
- R3: The driver transfer is issued in this order: START, WRITE 0xC0, WRITE 0x11, WRITE 0x00, WRITE `hold_duty`, WRITE 0x00, WRITE `close_duty`, STOP.
- R4: The NACK flag (`eng_nack`=1 together with `eng_done`) is acted on only when it completes a driver WRITE. In that case the next command is STOP, no further driver bytes are sent, and `drv_err` becomes 1 and stays 1 until reset. NACK on a START or STOP completion has no effect.
- R5: After the driver STOP, each DAC is configured in turn, first 0xC2 and then 0xC4. Each DAC receives DAC-RESET, START, WRITE address, WRITE `dac_cfg`, STOP.
- R6: NACK on any DAC command leaves the command order unchanged and leaves `drv_err` unchanged.
- R7: `init_done` becomes 1 after the completion of the final DAC STOP. It then stays 1, and no further command is issued. This holds with or without a driver error.
- R8: The `cmd_op` encoding is 0 = START, 1 = STOP, 2 = WRITE, 3 = DAC-RESET. `cmd_data` carries the byte for WRITE and is 0x00 for the other commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_duty | input | 8 | Duty byte for PWM channel 0 |
| close_duty | input | 8 | Duty byte for PWM channel 1 |
| dac_cfg | input | 8 | Configuration byte written to each DAC |
| eng_idle | input | 1 | Byte engine is ready to accept work |
| eng_done | input | 1 | Single-cycle completion of the current command |
| eng_nack | input | 1 | Byte was not acknowledged; valid with `eng_done` |
| cmd_valid | output | 1 | Single-cycle command request |
| cmd_op | output | 2 | Command code (see R8) |
| cmd_data | output | 8 | Byte to write |
| init_done | output | 1 | Script finished |
| drv_err | output | 1 | Driver transfer was cut short by a NACK |

## Verification
The bench builds the block with its default parameters: two DACs at 0xC2 and 0xC4, and driver address 0xC0 with control byte 0x11. The whole script is therefore 18 commands long, and the bench can sweep every case. It places a NACK on each of the six driver writes in turn, and also runs with no NACK. Each of these runs is repeated with and without NACKs on every DAC command and on the driver start and stop completions. The whole set is repeated at three engine latencies. The bench compares each complete command log against a list it builds from the requirements.

// File: rtl/i2c_init_pkg.sv
package i2c_init_pkg;

    typedef enum logic [1:0] {
        OP_START  = 2'd0,
        OP_STOP   = 2'd1,
        OP_WRITE  = 2'd2,
        OP_DACRST = 2'd3
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [7:0] data;
        logic       drv_phase;
        logic       last;
    } step_t;

    typedef enum logic [1:0] {
        ST_WAIT_IDLE = 2'd0,
        ST_ISSUE     = 2'd1,
        ST_WAIT_DONE = 2'd2,
        ST_FINISHED  = 2'd3
    } fsm_e;

    localparam int DRV_LEN = 8;
    localparam int DAC_LEN = 5;

endpackage

// File: rtl/i2c_init_script.sv
module i2c_init_script
    import i2c_init_pkg::*;
#(
    parameter logic [7:0] DRV_ADDR   = 8'hC0,
    parameter logic [7:0] DRV_CTRL   = 8'h11,
    parameter logic [7:0] DRV_PRESC  = 8'h00,
    parameter int         NUM_DAC    = 2,
    parameter logic [7:0] DAC_BASE   = 8'hC2,
    parameter int         DAC_STRIDE = 2,
    parameter int         SW         = 5
) (
    input  logic [SW-1:0] step_idx,
    input  logic [7:0]    hold_duty,
    input  logic [7:0]    close_duty,
    input  logic [7:0]    dac_cfg,
    output step_t         step
);

    localparam int TOTAL = DRV_LEN + DAC_LEN * NUM_DAC;

    logic [7:0] dac_addr [NUM_DAC];

    generate
        for (genvar gi = 0; gi < NUM_DAC; gi++) begin : g_addr
            assign dac_addr[gi] = DAC_BASE + 8'(DAC_STRIDE * gi);
        end
    endgenerate

    int rel_idx;
    int dac_no;
    int dac_pos;

    always_comb begin
        step     = '0;
        step.op  = OP_START;
        rel_idx  = int'(step_idx) - DRV_LEN;
        dac_no   = 0;
        dac_pos  = 0;
        if (int'(step_idx) < DRV_LEN) begin
            step.drv_phase = 1'b1;
            case (step_idx[2:0])
                3'd0: step.op = OP_START;
                3'd1: begin step.op = OP_WRITE; step.data = DRV_ADDR;   end
                3'd2: begin step.op = OP_WRITE; step.data = DRV_CTRL;   end
                3'd3: begin step.op = OP_WRITE; step.data = DRV_PRESC;  end
                3'd4: begin step.op = OP_WRITE; step.data = hold_duty;  end
                3'd5: begin step.op = OP_WRITE; step.data = DRV_PRESC;  end
                3'd6: begin step.op = OP_WRITE; step.data = close_duty; end
                default: step.op = OP_STOP;
            endcase
        end else begin
            dac_no  = rel_idx / DAC_LEN;
            dac_pos = rel_idx % DAC_LEN;
            case (dac_pos)
                0: step.op = OP_DACRST;
                1: step.op = OP_START;
                2: begin
                    step.op = OP_WRITE;
                    if (dac_no < NUM_DAC) step.data = dac_addr[dac_no];
                end
                3: begin step.op = OP_WRITE; step.data = dac_cfg; end
                default: step.op = OP_STOP;
            endcase
        end
        step.last = (int'(step_idx) == TOTAL - 1);
    end

endmodule

// File: rtl/i2c_init_ctrl.sv
module i2c_init_ctrl
    import i2c_init_pkg::*;
#(
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eng_idle,
    input  logic          eng_done,
    input  logic          eng_nack,
    input  step_t         step,
    output logic [SW-1:0] step_idx,
    output logic          cmd_valid,
    output logic [1:0]    cmd_op,
    output logic [7:0]    cmd_data,
    output logic          init_done,
    output logic          drv_err
);

    localparam logic [SW-1:0] DRV_STOP_IDX = SW'(DRV_LEN - 1);

    typedef struct packed {
        fsm_e          st;
        logic [SW-1:0] idx;
        logic          err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  abort_hit;

    always_comb begin
        ctl_d     = ctl_q;
        abort_hit = step.drv_phase && (step.op == OP_WRITE) && eng_nack;
        case (ctl_q.st)
            ST_WAIT_IDLE: begin
                if (eng_idle) ctl_d.st = ST_ISSUE;
            end
            ST_ISSUE: begin
                ctl_d.st = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (eng_done) begin
                    if (abort_hit) begin
                        ctl_d.err = 1'b1;
                        ctl_d.idx = DRV_STOP_IDX;
                        ctl_d.st  = ST_ISSUE;
                    end else if (step.last) begin
                        ctl_d.st  = ST_FINISHED;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                        ctl_d.st  = ST_ISSUE;
                    end
                end
            end
            default: ctl_d.st = ST_FINISHED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_WAIT_IDLE, idx: '0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign step_idx  = ctl_q.idx;
    assign cmd_valid = (ctl_q.st == ST_ISSUE);
    assign cmd_op    = step.op;
    assign cmd_data  = (step.op == OP_WRITE) ? step.data : 8'h00;
    assign init_done = (ctl_q.st == ST_FINISHED);
    assign drv_err   = ctl_q.err;

endmodule

// File: rtl/i2c_init_seq.sv
module i2c_init_seq
    import i2c_init_pkg::*;
#(
    parameter logic [7:0] DRV_ADDR   = 8'hC0,
    parameter logic [7:0] DRV_CTRL   = 8'h11,
    parameter logic [7:0] DRV_PRESC  = 8'h00,
    parameter int         NUM_DAC    = 2,
    parameter logic [7:0] DAC_BASE   = 8'hC2,
    parameter int         DAC_STRIDE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] hold_duty,
    input  logic [7:0] close_duty,
    input  logic [7:0] dac_cfg,
    input  logic       eng_idle,
    input  logic       eng_done,
    input  logic       eng_nack,
    output logic       cmd_valid,
    output logic [1:0] cmd_op,
    output logic [7:0] cmd_data,
    output logic       init_done,
    output logic       drv_err
);

    localparam int TOTAL = DRV_LEN + DAC_LEN * NUM_DAC;
    localparam int SW    = $clog2(TOTAL + 1);

    logic [SW-1:0] step_idx;
    step_t         step;

    i2c_init_script #(
        .DRV_ADDR   (DRV_ADDR),
        .DRV_CTRL   (DRV_CTRL),
        .DRV_PRESC  (DRV_PRESC),
        .NUM_DAC    (NUM_DAC),
        .DAC_BASE   (DAC_BASE),
        .DAC_STRIDE (DAC_STRIDE),
        .SW         (SW)
    ) u_script (
        .step_idx   (step_idx),
        .hold_duty  (hold_duty),
        .close_duty (close_duty),
        .dac_cfg    (dac_cfg),
        .step       (step)
    );

    i2c_init_ctrl #(
        .SW (SW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .eng_idle  (eng_idle),
        .eng_done  (eng_done),
        .eng_nack  (eng_nack),
        .step      (step),
        .step_idx  (step_idx),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .init_done (init_done),
        .drv_err   (drv_err)
    );

endmodule

// File: rtl/i2c_init_chk.sv
module i2c_init_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eng_idle,
    input logic       eng_done,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       init_done,
    input logic       drv_err
);

    logic       seen_idle_q;
    logic       pending_q;
    logic [1:0] last_op_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_idle_q <= 1'b0;
            pending_q   <= 1'b0;
            last_op_q   <= 2'd0;
        end else begin
            if (eng_idle) seen_idle_q <= 1'b1;
            if (cmd_valid) begin
                pending_q <= 1'b1;
                last_op_q <= cmd_op;
            end else if (eng_done) begin
                pending_q <= 1'b0;
            end
        end
    end

    assert_idle_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_idle_q |-> !cmd_valid);

    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_wait_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> !cmd_valid);

    assert_abort_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_err) |-> (cmd_valid && cmd_op == 2'd1));

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        drv_err |=> drv_err);

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !cmd_valid);

    assert_done_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (last_op_q == 2'd1 && !pending_q));

endmodule

bind i2c_init_seq i2c_init_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_idle  (eng_idle),
    .eng_done  (eng_done),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .init_done (init_done),
    .drv_err   (drv_err)
);

// File: tb/test_i2c_init_seq.sv
`timescale 1ns/1ps
module test_i2c_init_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hold_duty = 8'h00;
    logic [7:0] close_duty = 8'h00;
    logic [7:0] dac_cfg = 8'h00;
    logic       eng_idle;
    logic       eng_done;
    logic       eng_nack;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic [7:0] cmd_data;
    logic       init_done;
    logic       drv_err;

    always #10 clk = ~clk;

    i2c_init_seq i_i2c_init_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_duty  (hold_duty),
        .close_duty (close_duty),
        .dac_cfg    (dac_cfg),
        .eng_idle   (eng_idle),
        .eng_done   (eng_done),
        .eng_nack   (eng_nack),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_data   (cmd_data),
        .init_done  (init_done),
        .drv_err    (drv_err)
    );

    // Byte engine model
    logic [31:0] nack_mask = '0;
    int          lat = 0;
    logic        idle_en = 1'b1;
    logic        busy;
    int          cnt;
    int          cur;
    int          nlog;
    logic [1:0]  log_op  [32];
    logic [7:0]  log_dat [32];

    assign eng_idle = idle_en && !busy;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            eng_done <= 1'b0;
            eng_nack <= 1'b0;
            cnt      <= 0;
            cur      <= 0;
            nlog     <= 0;
        end else begin
            eng_done <= 1'b0;
            eng_nack <= 1'b0;
            if (cmd_valid && !busy) begin
                if (nlog < 32) begin
                    log_op[nlog]  <= cmd_op;
                    log_dat[nlog] <= cmd_data;
                end
                cur  <= nlog;
                nlog <= nlog + 1;
                busy <= 1'b1;
                cnt  <= lat;
            end else if (busy) begin
                if (cnt == 0) begin
                    busy     <= 1'b0;
                    eng_done <= 1'b1;
                    eng_nack <= (cur < 32) ? nack_mask[cur] : 1'b0;
                end else begin
                    cnt <= cnt - 1;
                end
            end
        end
    end

    int total = 0;
    int bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [1:0] exp_op  [32];
    logic [7:0] exp_dat [32];
    int         exp_n;

    task automatic push(input logic [1:0] op, input logic [7:0] d);
        exp_op[exp_n]  = op;
        exp_dat[exp_n] = d;
        exp_n++;
    endtask

    // k = log index of the NACKed driver write (1..6), 0 = none
    task automatic build(input int k, input logic [7:0] h, input logic [7:0] c, input logic [7:0] g);
        logic [7:0] w [6];
        w[0] = 8'hC0; w[1] = 8'h11; w[2] = 8'h00;
        w[3] = h;     w[4] = 8'h00; w[5] = c;
        exp_n = 0;
        push(2'd0, 8'h00);
        for (int i = 0; i < 6; i++) begin
            push(2'd2, w[i]);
            if (k == i + 1) break;
        end
        push(2'd1, 8'h00);
        for (int d = 0; d < 2; d++) begin
            push(2'd3, 8'h00);
            push(2'd0, 8'h00);
            push(2'd2, 8'(8'hC2 + 2 * d));
            push(2'd2, g);
            push(2'd1, 8'h00);
        end
    endtask

    task automatic run(input int k, input bit dn, input bit hold_idle);
        int dl;
        int waited;
        int n_at_done;
        hold_duty  = 8'(8'h40 + 3 * k + lat);
        close_duty = 8'(8'hA5 ^ (8'(k) << 4));
        dac_cfg    = 8'(8'h5A + 16 * dn + lat);
        dl = (k > 0) ? k + 2 : 8;
        nack_mask = '0;
        if (k > 0) nack_mask[k] = 1'b1;
        if (dn) begin
            nack_mask[0]      = 1'b1;
            nack_mask[dl - 1] = 1'b1;
            for (int i = dl; i < 32; i++) nack_mask[i] = 1'b1;
        end
        build(k, hold_duty, close_duty, dac_cfg);
        idle_en = !hold_idle;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!cmd_valid && !init_done && !drv_err, "R1 reset outputs",
              {cmd_valid, init_done, drv_err}, 0);
        rst_n = 1'b1;
        if (hold_idle) begin
            repeat (12) @(negedge clk);
            check(nlog == 0 && !cmd_valid, "R1 no command before idle", nlog, 0);
            idle_en = 1'b1;
        end
        waited = 0;
        while (!init_done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check(init_done == 1'b1, "R7 done raised", init_done, 1);
        n_at_done = nlog;
        check(nlog == exp_n, (k > 0) ? "R4 command count" : "R3 R5 command count", nlog, exp_n);
        for (int i = 0; i < exp_n && i < 32 && i < nlog; i++) begin
            check(log_op[i] == exp_op[i] && log_dat[i] == exp_dat[i],
                  (i < dl) ? ((k > 0) ? "R4 R8 driver cmd" : "R3 R8 driver cmd")
                           : (dn ? "R6 R8 dac cmd" : "R5 R8 dac cmd"),
                  {log_op[i], log_dat[i]}, {exp_op[i], exp_dat[i]});
        end
        check(drv_err == (k > 0), dn ? "R6 error flag" : "R4 error flag", drv_err, (k > 0));
        repeat (20) @(negedge clk);
        check(nlog == n_at_done && init_done && drv_err == (k > 0),
              "R7 quiet and held after done", nlog, n_at_done);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lats [3];
        lats[0] = 0; lats[1] = 1; lats[2] = 3;
        for (int li = 0; li < 3; li++) begin
            lat = lats[li];
            for (int k = 0; k <= 6; k++) begin
                for (int dn = 0; dn < 2; dn++) begin
                    run(k, dn[0], (li == 0 && dn == 0));
                end
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule